// File: doc/BRIEF.md
# Multiply-Accumulate Product and Readout Unit

This block is the arithmetic front and back end of a multiply-accumulate engine that keeps four 48-bit accumulators, each held in a 64-bit container. It forms 64-bit products of two 32-bit operands in signed integer, unsigned integer or signed fractional form. It detects when a product or an accumulator is too large and either clamps it or wraps it. It converts an accumulator into a 32-bit or 16-bit readout. It also derives zero, negative, overflow and extension status from an accumulator.

A single 12-bit mode word steers every operation and also collects the status it produces. The low four bits are controls: round, signed, fractional and saturate. The upper bits are sticky status: the overflow, zero, negative and extension flags, and one overflow bit per accumulator. Status bits are set by operations and are cleared only by reset or by loading a new mode word. One operation is issued per cycle with a valid strobe. The result and the updated mode word are registered and appear one cycle later.

Top module: `mac_prod_readout`

## Requirements
- R1: Reset clears `result`, `mode_q` and `out_valid`. An operation sampled with `in_valid` high updates `result` and `mode_q` at that clock edge and raises `out_valid` for one cycle. With `in_valid` low, `mode_q` and `result` hold and `out_valid` is low.
- R2: `op_sel` codes are 0 load mode, 1 signed multiply, 2 unsigned multiply, 3 fractional multiply, 4 saturate, 5 status, 6 readout and 7 no operation. Load copies `opnd_a[11:0]` into `mode_q`. Load and no operation both give `result` 0, and no operation leaves `mode_q` unchanged. The `mode_q` bits are: 0 round, 1 signed, 2 fractional, 3 saturate, 4 V, 5 Z, 6 N, 7 EV, and 8+k overflow of accumulator k.
- R3: A signed multiply whose 64-bit product fits 40 signed bits returns the product. Otherwise it sets V. With saturate off it returns the low 40 bits sign-extended. With saturate on it returns 2^50 for a non-negative product and the bitwise inverse of 2^50 for a negative one.
- R4: An unsigned multiply with any of product bits 63..40 set sets V. It then returns 2^50 with saturate on, or the product truncated to 40 bits with saturate off. Otherwise it returns the product.
- R5: A fractional multiply returns the signed product shifted arithmetically right by 24. With round on, it adds one when the 24 discarded bits exceed 0x800000, or when they equal 0x800000 and the shifted value is odd. It never sets V.
- R6: Saturate in signed integer mode (signed=1, fractional=0) sets V when `acc_in` does not fit 48 signed bits. If V is then set, whether new or already held, the overflow bit of `acc_sel` is also set. With saturate on, the result is clamped to 0x7FFFFFFF, or to 0xFFFFFFFF80000000 when bit 47 is set. Otherwise the result is `acc_in[47:0]` sign-extended.
- R7: Saturate in fractional mode detects overflow and sets V and the per-accumulator bit as in R6. With saturate on, the clamp is to 0x00007FFFFFFFFFFF or 0xFFFF800000000000.
- R8: Saturate in unsigned mode (signed=0, fractional=0) sets V when any of bits 63..48 is set, and sets the per-accumulator bit when V is set. If V is set: with saturate on, the result is 0 when `acc_in` exceeds 2^53 and 0x0000FFFFFFFFFFFF otherwise; with saturate off, the result is the low 48 bits. If V is not set, `acc_in` passes through unchanged.
- R9: Fractional readout is zero-extended into `result`. In 16-bit mode (signed=1) it rounds off 24 bits with ties to even. Otherwise it rounds off 8 bits with ties to even when round is on, and truncates 8 bits when round is off. With saturate on, a value that does not fit 16 or 32 signed bits becomes 0x7FFF/0x8000 or 0x7FFFFFFF/0x80000000 by sign. With saturate off, the low bits are kept.
- R10: Integer readout in signed mode returns the low 32 bits when `acc_in` fits 32 signed bits, and 0x7FFFFFFF or 0x80000000 by sign otherwise. In unsigned mode it returns 0xFFFFFFFF when any of bits 63..32 is set, and the low 32 bits otherwise. The readout is zero-extended into `result`.
- R11: The status operation returns `result` 0. It sets Z when `acc_in` is zero, and otherwise sets N when bit 47 is set. It sets V when the overflow bit of `acc_sel` is set. It sets EV when bits 63..40 (fractional), bits 63..32 (signed) are neither all zero nor all one, or when any of bits 63..32 is set (unsigned).
- R12: Every operation other than load leaves the control bits unchanged and never clears a status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| op_sel | input | 3 | Operation code |
| acc_sel | input | 2 | Accumulator index |
| opnd_a | input | 32 | First operand, or the new mode word on load |
| opnd_b | input | 32 | Second operand |
| acc_in | input | 64 | Accumulator value for saturate, status and readout |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| result | output | 64 | Product, saturated accumulator or readout |
| mode_q | output | 12 | Mode and sticky status word |

## Verification
In a saturate operation, detecting overflow and deciding to clamp happen in the same cycle. The clamp must act on the overflow found in that cycle, not only on the V bit already held. The bench provokes this by issuing a saturate with V clear and an accumulator outside 48 bits. It then checks in the same cycle that the clamp limit appears, that V is set and that the bit for the chosen accumulator is set. A companion case holds V already set with an in-range accumulator, and checks that the sticky flag alone still forces the clamp.

// File: rtl/mac_pkg.sv
package mac_pkg;
  localparam int OPW   = 32;
  localparam int PRW   = 2 * OPW;
  localparam int ACW   = 48;
  localparam int MFIT  = 40;
  localparam int FSH   = 24;
  localparam int RSH   = 8;
  localparam int HLW   = 16;
  localparam int WDW   = 32;
  localparam int BIGX  = 50;
  localparam int UCUT  = 53;

  localparam int MB_RND = 0;
  localparam int MB_SGN = 1;
  localparam int MB_FRC = 2;
  localparam int MB_SAT = 3;
  localparam int MB_V   = 4;
  localparam int MB_Z   = 5;
  localparam int MB_N   = 6;
  localparam int MB_EV  = 7;
  localparam int MB_PAV = 8;

  typedef enum logic [2:0] {
    OP_LOAD  = 3'd0,
    OP_MULS  = 3'd1,
    OP_MULU  = 3'd2,
    OP_MULF  = 3'd3,
    OP_SAT   = 3'd4,
    OP_FLAGS = 3'd5,
    OP_READ  = 3'd6,
    OP_NOP   = 3'd7
  } op_e;

  // round-half-to-even increment on a floor-shifted value
  function automatic logic [PRW-1:0] rne(input logic [PRW-1:0] q,
                                         input logic above,
                                         input logic tie);
    return q + PRW'(above | (tie & q[0]));
  endfunction
endpackage

// File: rtl/mac_mult.sv
module mac_mult
  import mac_pkg::*;
(
  input  logic [OPW-1:0] a,
  input  logic [OPW-1:0] b,
  input  op_e            op,
  input  logic           rnd,
  input  logic           sat,
  output logic [PRW-1:0] prod,
  output logic           ovf
);
  localparam logic [PRW-1:0] BIG  = PRW'(1) << BIGX;
  localparam logic [FSH-1:0] HALF = FSH'(1) << (FSH - 1);

  logic signed [PRW-1:0] ps;
  logic [PRW-1:0]        pu;
  logic [PRW-1:0]        s_wrap;
  logic [PRW-1:0]        fq;
  logic [FSH-1:0]        frem;
  logic                  s_fit;
  logic                  u_fit;

  assign ps     = $signed({{OPW{a[OPW-1]}}, a}) * $signed({{OPW{b[OPW-1]}}, b});
  assign pu     = {{OPW{1'b0}}, a} * {{OPW{1'b0}}, b};
  assign s_fit  = (ps[PRW-1:MFIT-1] == {(PRW-MFIT+1){ps[MFIT-1]}});
  assign u_fit  = ~|pu[PRW-1:MFIT];
  assign s_wrap = {{(PRW-MFIT){ps[MFIT-1]}}, ps[MFIT-1:0]};
  assign fq     = ps >>> FSH;
  assign frem   = ps[FSH-1:0];

  always_comb begin
    ovf  = 1'b0;
    prod = '0;
    case (op)
      OP_MULS: begin
        ovf = ~s_fit;
        if (s_fit)    prod = ps;
        else if (sat) prod = ps[PRW-1] ? ~BIG : BIG;
        else          prod = s_wrap;
      end
      OP_MULU: begin
        ovf = ~u_fit;
        if (u_fit)    prod = pu;
        else if (sat) prod = BIG;
        else          prod = {{(PRW-MFIT){1'b0}}, pu[MFIT-1:0]};
      end
      OP_MULF: begin
        prod = rnd ? rne(fq, frem > HALF, frem == HALF) : fq;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/mac_accsat.sv
module mac_accsat
  import mac_pkg::*;
(
  input  logic [PRW-1:0] acc,
  input  logic           frc,
  input  logic           sgn,
  input  logic           sat,
  input  logic           v_in,
  output logic [PRW-1:0] res,
  output logic           v_out
);
  localparam logic [PRW-1:0] LIM_W = PRW'((64'd1 << (WDW - 1)) - 64'd1);
  localparam logic [PRW-1:0] LIM_A = PRW'((64'd1 << (ACW - 1)) - 64'd1);
  localparam logic [PRW-1:0] UMAX  = PRW'((64'd1 << ACW) - 64'd1);
  localparam logic [PRW-1:0] UCAP  = PRW'(1) << UCUT;

  logic           fit_s;
  logic           ovf_s;
  logic           ovf_u;
  logic [PRW-1:0] sext;

  assign fit_s = (acc[PRW-1:ACW-1] == {(PRW-ACW+1){acc[ACW-1]}});
  assign ovf_s = ~fit_s;
  assign ovf_u = |acc[PRW-1:ACW];
  assign sext  = {{(PRW-ACW){acc[ACW-1]}}, acc[ACW-1:0]};

  always_comb begin
    if (frc || sgn) begin
      v_out = v_in | ovf_s;
      res   = sext;
      if (v_out && sat) begin
        if (frc) res = acc[ACW-1] ? ~LIM_A : LIM_A;
        else     res = acc[ACW-1] ? ~LIM_W : LIM_W;
      end
    end else begin
      v_out = v_in | ovf_u;
      res   = acc;
      if (v_out) begin
        if (sat) res = (acc > UCAP) ? '0 : UMAX;
        else     res = acc & UMAX;
      end
    end
  end
endmodule

// File: rtl/mac_readout.sv
module mac_readout
  import mac_pkg::*;
(
  input  logic [PRW-1:0] acc,
  input  logic           frc,
  input  logic           sgn,
  input  logic           rnd,
  input  logic           sat,
  output logic [PRW-1:0] rd
);
  localparam logic [FSH-1:0] HALF_H = FSH'(1) << (FSH - 1);
  localparam logic [RSH-1:0] HALF_W = RSH'(1) << (RSH - 1);

  logic [PRW-1:0] qh_raw;
  logic [PRW-1:0] qh;
  logic [PRW-1:0] qw_raw;
  logic [PRW-1:0] qw;
  logic           fit_h;
  logic           fit_w;
  logic           fit_i;
  logic [HLW-1:0] out_h;
  logic [WDW-1:0] out_w;
  logic [WDW-1:0] out_i;

  assign qh_raw = $signed(acc) >>> FSH;
  assign qh     = rne(qh_raw, acc[FSH-1:0] > HALF_H, acc[FSH-1:0] == HALF_H);
  assign qw_raw = $signed(acc) >>> RSH;
  assign qw     = rnd ? rne(qw_raw, acc[RSH-1:0] > HALF_W, acc[RSH-1:0] == HALF_W)
                      : qw_raw;
  assign fit_h  = (qh[PRW-1:HLW-1] == {(PRW-HLW+1){qh[HLW-1]}});
  assign fit_w  = (qw[PRW-1:WDW-1] == {(PRW-WDW+1){qw[WDW-1]}});
  assign fit_i  = (acc[PRW-1:WDW-1] == {(PRW-WDW+1){acc[WDW-1]}});

  always_comb begin
    if (sat && !fit_h) out_h = qh[PRW-1] ? {1'b1, {(HLW-1){1'b0}}} : {1'b0, {(HLW-1){1'b1}}};
    else               out_h = qh[HLW-1:0];
    if (sat && !fit_w) out_w = qw[PRW-1] ? {1'b1, {(WDW-1){1'b0}}} : {1'b0, {(WDW-1){1'b1}}};
    else               out_w = qw[WDW-1:0];
    if (sgn) begin
      if (fit_i) out_i = acc[WDW-1:0];
      else       out_i = acc[PRW-1] ? {1'b1, {(WDW-1){1'b0}}} : {1'b0, {(WDW-1){1'b1}}};
    end else begin
      out_i = (|acc[PRW-1:WDW]) ? '1 : acc[WDW-1:0];
    end
    if (frc && sgn) rd = {{(PRW-HLW){1'b0}}, out_h};
    else if (frc)   rd = {{(PRW-WDW){1'b0}}, out_w};
    else            rd = {{(PRW-WDW){1'b0}}, out_i};
  end
endmodule

// File: rtl/mac_flags.sv
module mac_flags
  import mac_pkg::*;
(
  input  logic [PRW-1:0] acc,
  input  logic           frc,
  input  logic           sgn,
  input  logic           pav_bit,
  output logic           z,
  output logic           n,
  output logic           v,
  output logic           ev
);
  logic hi_f_mixed;
  logic hi_s_mixed;

  assign hi_f_mixed = (|acc[PRW-1:MFIT]) && !(&acc[PRW-1:MFIT]);
  assign hi_s_mixed = (|acc[PRW-1:WDW])  && !(&acc[PRW-1:WDW]);
  assign z  = (acc == '0);
  assign n  = !z && acc[ACW-1];
  assign v  = pav_bit;
  assign ev = frc ? hi_f_mixed : (sgn ? hi_s_mixed : |acc[PRW-1:WDW]);
endmodule

// File: rtl/mac_prod_readout.sv
module mac_prod_readout
  import mac_pkg::*;
#(
  parameter  int NUM_ACC = 4,
  localparam int IDXW    = (NUM_ACC > 1) ? $clog2(NUM_ACC) : 1,
  localparam int MW      = MB_PAV + NUM_ACC
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [2:0]      op_sel,
  input  logic [IDXW-1:0] acc_sel,
  input  logic [OPW-1:0]  opnd_a,
  input  logic [OPW-1:0]  opnd_b,
  input  logic [PRW-1:0]  acc_in,
  output logic            out_valid,
  output logic [PRW-1:0]  result,
  output logic [MW-1:0]   mode_q
);
  op_e                op;
  logic [NUM_ACC-1:0] pav;
  logic [NUM_ACC-1:0] pav_hit;
  logic [PRW-1:0]     m_prod;
  logic               m_ovf;
  logic [PRW-1:0]     s_res;
  logic               s_v;
  logic [PRW-1:0]     r_rd;
  logic               f_z, f_n, f_v, f_ev;
  logic [MW-1:0]      nxt_mode;
  logic [PRW-1:0]     nxt_res;

  assign op  = op_e'(op_sel);
  assign pav = mode_q[MB_PAV +: NUM_ACC];

  for (genvar g = 0; g < NUM_ACC; g++) begin : g_pav
    assign pav_hit[g] = (acc_sel == IDXW'(g));
  end

  mac_mult u_mult (
    .a(opnd_a), .b(opnd_b), .op(op),
    .rnd(mode_q[MB_RND]), .sat(mode_q[MB_SAT]),
    .prod(m_prod), .ovf(m_ovf)
  );

  mac_accsat u_accsat (
    .acc(acc_in), .frc(mode_q[MB_FRC]), .sgn(mode_q[MB_SGN]),
    .sat(mode_q[MB_SAT]), .v_in(mode_q[MB_V]),
    .res(s_res), .v_out(s_v)
  );

  mac_readout u_readout (
    .acc(acc_in), .frc(mode_q[MB_FRC]), .sgn(mode_q[MB_SGN]),
    .rnd(mode_q[MB_RND]), .sat(mode_q[MB_SAT]), .rd(r_rd)
  );

  mac_flags u_flags (
    .acc(acc_in), .frc(mode_q[MB_FRC]), .sgn(mode_q[MB_SGN]),
    .pav_bit(pav[acc_sel]),
    .z(f_z), .n(f_n), .v(f_v), .ev(f_ev)
  );

  always_comb begin
    nxt_mode = mode_q;
    nxt_res  = '0;
    case (op)
      OP_LOAD: nxt_mode = opnd_a[MW-1:0];
      OP_MULS, OP_MULU, OP_MULF: begin
        nxt_res = m_prod;
        if (m_ovf) nxt_mode[MB_V] = 1'b1;
      end
      OP_SAT: begin
        nxt_res = s_res;
        if (s_v) begin
          nxt_mode[MB_V]               = 1'b1;
          nxt_mode[MB_PAV +: NUM_ACC]  = pav | pav_hit;
        end
      end
      OP_FLAGS: begin
        if (f_z)  nxt_mode[MB_Z]  = 1'b1;
        if (f_n)  nxt_mode[MB_N]  = 1'b1;
        if (f_v)  nxt_mode[MB_V]  = 1'b1;
        if (f_ev) nxt_mode[MB_EV] = 1'b1;
      end
      OP_READ: nxt_res = r_rd;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      mode_q    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result <= nxt_res;
        mode_q <= nxt_mode;
      end
    end
  end
endmodule

// File: rtl/mac_prod_readout_chk.sv
module mac_prod_readout_chk
  import mac_pkg::*;
#(
  parameter  int NUM_ACC = 4,
  localparam int IDXW    = (NUM_ACC > 1) ? $clog2(NUM_ACC) : 1,
  localparam int MW      = MB_PAV + NUM_ACC
) (
  input logic            clk,
  input logic            rst,
  input logic            in_valid,
  input logic [2:0]      op_sel,
  input logic [IDXW-1:0] acc_sel,
  input logic [PRW-1:0]  acc_in,
  input logic            out_valid,
  input logic [PRW-1:0]  result,
  input logic [MW-1:0]   mode_q
);
  logic [NUM_ACC-1:0] pav_now;
  logic               acc_out48;

  assign pav_now   = mode_q[MB_PAV +: NUM_ACC];
  assign acc_out48 = (acc_in[PRW-1:ACW-1] != {(PRW-ACW+1){acc_in[ACW-1]}});

  p_valid_follows_r1: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  p_idle_hold_r1: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(mode_q) && $stable(result)));

  p_no_clear_r12: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_sel != OP_LOAD) |=> ((mode_q & $past(mode_q)) == $past(mode_q)));

  p_mulu_width_r4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_sel == OP_MULU && !mode_q[MB_SAT]) |=> (result[PRW-1:MFIT] == '0));

  p_sats_clamp_r6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_sel == OP_SAT && !mode_q[MB_FRC] && mode_q[MB_SGN] &&
     mode_q[MB_SAT] && acc_out48)
    |=> (result == 64'h0000_0000_7FFF_FFFF || result == 64'hFFFF_FFFF_8000_0000));

  p_pav_set_r6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_sel == OP_SAT && (mode_q[MB_FRC] || mode_q[MB_SGN]) && acc_out48)
    |=> (mode_q[MB_V] && pav_now[$past(acc_sel)]));

  p_readu_cap_r10: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_sel == OP_READ && !mode_q[MB_FRC] && !mode_q[MB_SGN] &&
     (|acc_in[PRW-1:WDW])) |=> (result == 64'h0000_0000_FFFF_FFFF));
endmodule

bind mac_prod_readout mac_prod_readout_chk #(.NUM_ACC(NUM_ACC)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .op_sel(op_sel), .acc_sel(acc_sel),
  .acc_in(acc_in), .out_valid(out_valid), .result(result), .mode_q(mode_q)
);

// File: tb/mac_prod_readout_bench.sv
`timescale 1ns/1ps
module mac_prod_readout_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [2:0]  op_sel = 3'd0;
  logic [1:0]  acc_sel = 2'd0;
  logic [31:0] opnd_a = '0;
  logic [31:0] opnd_b = '0;
  logic [63:0] acc_in = '0;
  logic        out_valid;
  logic [63:0] result;
  logic [11:0] mode_q;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  mac_prod_readout u_mac_prod_readout (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_sel(op_sel), .acc_sel(acc_sel),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .acc_in(acc_in),
    .out_valid(out_valid), .result(result), .mode_q(mode_q)
  );

  typedef struct packed {
    logic [2:0]  op;
    logic [1:0]  idx;
    logic [11:0] mode;
    logic [31:0] a;
    logic [31:0] b;
    logic [63:0] acc;
    logic [63:0] er;
    logic [11:0] em;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 40;
  localparam vec_t VEC [NV] = '{
    // R3 signed multiply
    '{3'd1, 2'd0, 12'h000, 32'h3,        32'hFFFFFFFB, 64'h0, 64'hFFFFFFFFFFFFFFF1, 12'h000, 4'd3},
    '{3'd1, 2'd0, 12'h000, 32'h40000000, 32'h40000000, 64'h0, 64'h0,                12'h010, 4'd3},
    '{3'd1, 2'd0, 12'h008, 32'h40000000, 32'h40000000, 64'h0, 64'h0004000000000000, 12'h018, 4'd3},
    '{3'd1, 2'd0, 12'h008, 32'h40000000, 32'hC0000000, 64'h0, 64'hFFFBFFFFFFFFFFFF, 12'h018, 4'd3},
    // R4 unsigned multiply
    '{3'd2, 2'd0, 12'h000, 32'hFFFFFFFF, 32'h2,        64'h0, 64'h00000001FFFFFFFE, 12'h000, 4'd4},
    '{3'd2, 2'd0, 12'h000, 32'h10000000, 32'h00100000, 64'h0, 64'h0,                12'h010, 4'd4},
    '{3'd2, 2'd0, 12'h008, 32'h10000000, 32'h00100000, 64'h0, 64'h0004000000000000, 12'h018, 4'd4},
    // R5 fractional multiply
    '{3'd3, 2'd0, 12'h000, 32'h00C00000, 32'h1, 64'h0, 64'h0,                12'h000, 4'd5},
    '{3'd3, 2'd0, 12'h001, 32'h00C00000, 32'h1, 64'h0, 64'h1,                12'h001, 4'd5},
    '{3'd3, 2'd0, 12'h001, 32'h00800000, 32'h3, 64'h0, 64'h2,                12'h001, 4'd5},
    '{3'd3, 2'd0, 12'h001, 32'h00800000, 32'h1, 64'h0, 64'h0,                12'h001, 4'd5},
    '{3'd3, 2'd0, 12'h001, 32'hFF800000, 32'h1, 64'h0, 64'h0,                12'h001, 4'd5},
    '{3'd3, 2'd0, 12'h000, 32'hFF800000, 32'h1, 64'h0, 64'hFFFFFFFFFFFFFFFF, 12'h000, 4'd5},
    // R6 signed saturate
    '{3'd4, 2'd1, 12'h00A, 32'h0, 32'h0, 64'h0001000000000000, 64'h000000007FFFFFFF, 12'h21A, 4'd6},
    '{3'd4, 2'd0, 12'h002, 32'h0, 32'h0, 64'h0001000000001234, 64'h0000000000001234, 12'h112, 4'd6},
    '{3'd4, 2'd2, 12'h00A, 32'h0, 32'h0, 64'hFFFFFF0000000000, 64'hFFFFFF0000000000, 12'h00A, 4'd6},
    '{3'd4, 2'd0, 12'h01A, 32'h0, 32'h0, 64'h0000000000000005, 64'h000000007FFFFFFF, 12'h11A, 4'd6},
    // R7 fractional saturate
    '{3'd4, 2'd3, 12'h00C, 32'h0, 32'h0, 64'hFF00800000000000, 64'hFFFF800000000000, 12'h81C, 4'd7},
    '{3'd4, 2'd3, 12'h004, 32'h0, 32'h0, 64'hFF00800000000000, 64'hFFFF800000000000, 12'h814, 4'd7},
    // R8 unsigned saturate
    '{3'd4, 2'd0, 12'h008, 32'h0, 32'h0, 64'h0001000000000005, 64'h0000FFFFFFFFFFFF, 12'h118, 4'd8},
    '{3'd4, 2'd0, 12'h008, 32'h0, 32'h0, 64'hFFFF000000000000, 64'h0,                12'h118, 4'd8},
    '{3'd4, 2'd1, 12'h000, 32'h0, 32'h0, 64'h0003000000000042, 64'h42,               12'h210, 4'd8},
    // R11 status
    '{3'd5, 2'd0, 12'h000, 32'h0, 32'h0, 64'h0,                64'h0, 12'h020, 4'd11},
    '{3'd5, 2'd0, 12'h002, 32'h0, 32'h0, 64'hFFFF800000000001, 64'h0, 12'h0C2, 4'd11},
    '{3'd5, 2'd2, 12'h404, 32'h0, 32'h0, 64'h000000FF00000000, 64'h0, 12'h414, 4'd11},
    '{3'd5, 2'd1, 12'h000, 32'h0, 32'h0, 64'h0000000100000000, 64'h0, 12'h080, 4'd11},
    // R10 integer readout
    '{3'd6, 2'd0, 12'h000, 32'h0, 32'h0, 64'h0000000100000000, 64'hFFFFFFFF, 12'h000, 4'd10},
    '{3'd6, 2'd0, 12'h000, 32'h0, 32'h0, 64'h0000000000001234, 64'h1234,     12'h000, 4'd10},
    '{3'd6, 2'd0, 12'h002, 32'h0, 32'h0, 64'hFFFFFFFF80000000, 64'h80000000, 12'h002, 4'd10},
    '{3'd6, 2'd0, 12'h002, 32'h0, 32'h0, 64'h0000000100000000, 64'h7FFFFFFF, 12'h002, 4'd10},
    '{3'd6, 2'd0, 12'h002, 32'h0, 32'h0, 64'hFFFFFFFE00000000, 64'h80000000, 12'h002, 4'd10},
    // R9 fractional readout
    '{3'd6, 2'd0, 12'h004, 32'h0, 32'h0, 64'h00000012345678FF, 64'h12345678, 12'h004, 4'd9},
    '{3'd6, 2'd0, 12'h005, 32'h0, 32'h0, 64'h0000000000000180, 64'h2,        12'h005, 4'd9},
    '{3'd6, 2'd0, 12'h005, 32'h0, 32'h0, 64'h0000000000000280, 64'h2,        12'h005, 4'd9},
    '{3'd6, 2'd0, 12'h006, 32'h0, 32'h0, 64'h0000000012800000, 64'h12,       12'h006, 4'd9},
    '{3'd6, 2'd0, 12'h006, 32'h0, 32'h0, 64'h0000000013800001, 64'h14,       12'h006, 4'd9},
    '{3'd6, 2'd0, 12'h00E, 32'h0, 32'h0, 64'h0000010000000000, 64'h7FFF,     12'h00E, 4'd9},
    '{3'd6, 2'd0, 12'h00C, 32'h0, 32'h0, 64'hFFFFFF0000000000, 64'h80000000, 12'h00C, 4'd9},
    '{3'd6, 2'd0, 12'h004, 32'h0, 32'h0, 64'h0000010000000000, 64'h0,        12'h004, 4'd9},
    // R2 no operation
    '{3'd7, 2'd0, 12'h010, 32'hFFF, 32'hFFF, 64'hFFFF, 64'h0, 12'h010, 4'd2}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] op, input logic [1:0] idx,
                       input logic [31:0] a, input logic [31:0] b,
                       input logic [63:0] acc);
    @(negedge clk);
    in_valid = 1'b1; op_sel = op; acc_sel = idx;
    opnd_a = a; opnd_b = b; acc_in = acc;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 reset result", result, 64'h0);
    chk("R1 reset mode", {52'h0, mode_q}, 64'h0);
    chk("R1 reset valid", {63'h0, out_valid}, 64'h0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      issue(3'd0, 2'd0, {20'h0, VEC[i].mode}, 32'h0, 64'h0);
      issue(VEC[i].op, VEC[i].idx, VEC[i].a, VEC[i].b, VEC[i].acc);
      chk($sformatf("R%0d vector %0d result", VEC[i].req, i), result, VEC[i].er);
      chk($sformatf("R%0d vector %0d mode", VEC[i].req, i), {52'h0, mode_q}, {52'h0, VEC[i].em});
    end

    // R1 one-cycle strobe and hold while idle
    issue(3'd0, 2'd0, 32'h0000_0005, 32'h0, 64'h0);
    chk("R1 valid after strobe", {63'h0, out_valid}, 64'h1);
    @(negedge clk);
    chk("R1 valid drops", {63'h0, out_valid}, 64'h0);
    op_sel = 3'd0; opnd_a = 32'hFFF;
    repeat (3) @(negedge clk);
    chk("R1 idle mode hold", {52'h0, mode_q}, 64'h5);

    // R2 load returns zero result and replaces the status bits
    issue(3'd1, 2'd0, 32'h7, 32'h3, 64'h0);
    chk("R2 product before load", result, 64'd21);
    issue(3'd0, 2'd0, 32'h0000_0FF0, 32'h0, 64'h0);
    chk("R2 load result", result, 64'h0);
    chk("R2 load mode", {52'h0, mode_q}, 64'hFF0);
    issue(3'd0, 2'd0, 32'h0, 32'h0, 64'h0);
    chk("R2 load clears status", {52'h0, mode_q}, 64'h0);

    // R12 status never cleared by other operations
    issue(3'd0, 2'd0, 32'h0000_00F0, 32'h0, 64'h0);
    issue(3'd1, 2'd0, 32'h3, 32'hFFFFFFFB, 64'h0);
    chk("R12 multiply keeps status", {52'h0, mode_q}, 64'h0F0);
    issue(3'd5, 2'd0, 32'h0, 32'h0, 64'h0000_0000_0000_0001);
    chk("R12 status op keeps status", {52'h0, mode_q}, 64'h0F0);
    issue(3'd4, 2'd3, 32'h0, 32'h0, 64'h0000_0000_0000_0009);
    chk("R12 saturate keeps status", {52'h0, mode_q}, 64'h8F0);

    // R1 reset while busy
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R1 reset clears mode", {52'h0, mode_q}, 64'h0);
    chk("R1 reset clears result", result, 64'h0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule